// File: doc/BRIEF.md
# Light Measurement Conversion Sequencer

This block drives the counting side of an integrating light-to-digital converter. A host writes two configuration bytes. One byte carries a 3-bit operating mode. The other carries a 2-bit resolution code and a 2-bit full-scale range code. From these the block selects either the visible (ALS) channel or the infrared channel. It then opens a counting window of 2^n clock cycles, where n is 16, 12, 8 or 4. Over that window it counts the strobes of a charge-balancing modulator. When the window closes, the count is latched into a 16-bit result register.

In a one-shot mode the block finishes a single window and then powers down. The result stays readable until a later conversion replaces it. In a continuous mode a new window opens on the cycle after the previous one closes, and each window overwrites the result. The range code plays no part in the counting. It is simply presented on a gain-select output for the analog front end.

Top module: `light_conv_seq`

## Requirements
- R1: After reset, result is 0, busy and done are low, gain_sel is 0, and the block is powered down.
- R2: The mode field is wr_data[7:5] on a mode write. Code 001 runs an ALS one-shot, 010 an IR one-shot, 101 ALS continuous and 110 IR continuous. While one of these modes is held, chan_ir is 1 for the IR codes and 0 for the ALS codes, and busy rises on the clock edge that captures the write.
- R3: Codes 000, 011, 100 and 111 start no conversion. busy stays low, no done pulse occurs and the result is unchanged, whatever the pulse input does.
- R4: The resolution field is wr_data[3:2] on a control write. Code 00 gives a 65,536-cycle window, 01 gives 4,096, 10 gives 256 and 11 gives 16. The pulse input is sampled on the window's clock edges, from the first edge after the starting write up to and including the closing edge. done is high in the cycle that follows the closing edge.
- R5: The result equals the number of sampled edges at which the pulse input was high. The count sits from bit 0 upward, and all bits above the selected width n are zero.
- R6: The count saturates at 2^n−1. A full 16-bit window with the pulse always high therefore gives 65535.
- R7: In a one-shot mode exactly one window runs. busy then falls together with the done pulse, and the result holds while later pulses arrive.
- R8: In a continuous mode the next window starts on the edge after the closing edge, with no gap, and each window overwrites the result.
- R9: A mode or control write during a window abandons that window without a done pulse and keeps the old result. If the mode left in place is an active one, a fresh window starts under the new settings; a control write also restarts a finished one-shot.
- R10: done is a one-cycle pulse that occurs only when the result register is loaded.
- R11: The range field is wr_data[1:0] on a control write. It appears unchanged on gain_sel from the next cycle on.
- R12: A mode write of 000 during a continuous run stops it on the capturing edge, with busy low and no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode byte (mode in bits 7:5) |
| ctrl_wr | input | 1 | Write strobe for the control byte (resolution in 3:2, range in 1:0) |
| wr_data | input | 8 | Configuration byte |
| mod_pulse | input | 1 | Modulator strobe, one count per high cycle |
| result | output | 16 | Last latched conversion count |
| done | output | 1 | One-cycle pulse when the result is loaded |
| busy | output | 1 | High while a window is open |
| chan_ir | output | 1 | Channel select: 1 for IR, 0 for ALS |
| gain_sel | output | 2 | Full-scale range select passed to the front end |

## Verification
The assertions take several things for granted. mod_pulse is a clean synchronous strobe. Configuration writes are single-cycle strobes. Windows are at least two cycles long, so two done pulses can never touch. The stimulus holds every input steady across each rising edge by changing it only on the falling edge. It raises each write strobe for exactly one edge. It holds mod_pulse low in the cycle of a write, so no pulse falls on an aborting edge. A scoreboard records the expected count and the closing cycle of every window, so a window that ends late, ends early or ends more than once shows up as a mismatch.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int LCS_CNT_W   = 16;
  localparam int LCS_STEP_W  = 4;
  localparam int LCS_RES_W   = 2;
  localparam int LCS_MODE_W  = 3;
  localparam int LCS_RANGE_W = 2;
  localparam int LCS_DATA_W  = 8;

  // operating mode codes
  localparam logic [LCS_MODE_W-1:0] MODE_OFF      = 3'b000;
  localparam logic [LCS_MODE_W-1:0] MODE_ALS_ONCE = 3'b001;
  localparam logic [LCS_MODE_W-1:0] MODE_IR_ONCE  = 3'b010;
  localparam logic [LCS_MODE_W-1:0] MODE_ALS_CONT = 3'b101;
  localparam logic [LCS_MODE_W-1:0] MODE_IR_CONT  = 3'b110;

  typedef struct packed {
    logic active;
    logic cont;
    logic ir;
  } lcs_mode_t;
endpackage

// File: rtl/lcs_mode_decode.sv
module lcs_mode_decode
  import lcs_pkg::*;
#(
  parameter int MODE_W = LCS_MODE_W
) (
  input  logic [MODE_W-1:0] mode,
  output lcs_mode_t         dec
);
  always_comb begin
    dec = '0;
    case (mode)
      MODE_ALS_ONCE: dec = '{active: 1'b1, cont: 1'b0, ir: 1'b0};
      MODE_IR_ONCE:  dec = '{active: 1'b1, cont: 1'b0, ir: 1'b1};
      MODE_ALS_CONT: dec = '{active: 1'b1, cont: 1'b1, ir: 1'b0};
      MODE_IR_CONT:  dec = '{active: 1'b1, cont: 1'b1, ir: 1'b1};
      default:       dec = '0; // power-down and reserved codes
    endcase
  end
endmodule

// File: rtl/lcs_res_cap.sv
module lcs_res_cap #(
  parameter int CNT_W  = 16,
  parameter int STEP_W = 4,
  parameter int RES_W  = 2
) (
  input  logic [RES_W-1:0] res,
  output logic [CNT_W-1:0] cap
);
  localparam int NCODE = 2 ** RES_W;

  logic [CNT_W-1:0] cap_tbl [NCODE];

  // code g selects CNT_W - STEP_W*g result bits; cap is the all-ones value
  for (genvar g = 0; g < NCODE; g++) begin : g_cap
    assign cap_tbl[g] = {CNT_W{1'b1}} >> (STEP_W * g);
  end

  assign cap = cap_tbl[res];
endmodule

// File: rtl/lcs_window_timer.sv
module lcs_window_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] cap,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  always_comb begin
    cnt_nx = cnt_q;
    if (clr)     cnt_nx = '0;
    else if (en) cnt_nx = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nx;
  end

  assign last = (cnt_q == cap);

  AST_WIN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= cap)); // R4
endmodule

// File: rtl/lcs_pulse_accum.sv
module lcs_pulse_accum #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             pulse,
  input  logic [CNT_W-1:0] cap,
  output logic [CNT_W-1:0] sum
);
  logic [CNT_W-1:0] acc_q;
  logic [CNT_W-1:0] acc_nx;

  // sum includes the current cycle's strobe and never passes cap
  always_comb begin
    sum = acc_q;
    if (pulse && (acc_q != cap)) sum = acc_q + 1'b1;
    acc_nx = acc_q;
    if (clr)     acc_nx = '0;
    else if (en) acc_nx = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_nx;
  end

  AST_ACC_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (acc_q <= cap)); // R6
endmodule

// File: rtl/light_conv_seq.sv
module light_conv_seq
  import lcs_pkg::*;
#(
  parameter int CNT_W     = LCS_CNT_W,
  parameter int STEP_W    = LCS_STEP_W,
  parameter int RES_W     = LCS_RES_W,
  parameter int MODE_W    = LCS_MODE_W,
  parameter int RANGE_W   = LCS_RANGE_W,
  parameter int DATA_W    = LCS_DATA_W,
  parameter int MODE_LSB  = 5,
  parameter int RES_LSB   = 2,
  parameter int RANGE_LSB = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mode_wr,
  input  logic               ctrl_wr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               mod_pulse,
  output logic [CNT_W-1:0]   result,
  output logic               done,
  output logic               busy,
  output logic               chan_ir,
  output logic [RANGE_W-1:0] gain_sel
);
  // configuration registers
  logic [MODE_W-1:0]  mode_q,  mode_nx;
  logic [RES_W-1:0]   res_q,   res_nx;
  logic [RANGE_W-1:0] range_q, range_nx;
  // sequencing state
  logic               run_q,   run_nx;
  logic               done_q,  done_nx;
  logic [CNT_W-1:0]   result_q, result_nx;

  logic               cfg_evt;
  logic               win_end;
  logic               cnt_clr;
  logic               last;
  logic [CNT_W-1:0]   cap;
  logic [CNT_W-1:0]   sum;
  lcs_mode_t          dec_cur;
  lcs_mode_t          dec_nx;

  lcs_mode_decode #(.MODE_W(MODE_W)) u_dec_cur (.mode(mode_q),  .dec(dec_cur));
  lcs_mode_decode #(.MODE_W(MODE_W)) u_dec_nx  (.mode(mode_nx), .dec(dec_nx));

  lcs_res_cap #(.CNT_W(CNT_W), .STEP_W(STEP_W), .RES_W(RES_W)) u_cap (
    .res (res_q),
    .cap (cap)
  );

  lcs_window_timer #(.CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (run_q),
    .cap   (cap),
    .last  (last)
  );

  lcs_pulse_accum #(.CNT_W(CNT_W)) u_accum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (run_q),
    .pulse (mod_pulse),
    .cap   (cap),
    .sum   (sum)
  );

  // next-state logic
  always_comb begin
    cfg_evt  = mode_wr | ctrl_wr;
    mode_nx  = mode_wr ? wr_data[MODE_LSB +: MODE_W]   : mode_q;
    res_nx   = ctrl_wr ? wr_data[RES_LSB +: RES_W]     : res_q;
    range_nx = ctrl_wr ? wr_data[RANGE_LSB +: RANGE_W] : range_q;

    win_end  = run_q & last;
    cnt_clr  = cfg_evt | win_end;

    if (cfg_evt)      run_nx = dec_nx.active;
    else if (win_end) run_nx = dec_cur.cont;
    else              run_nx = run_q;

    done_nx   = win_end & ~cfg_evt;
    result_nx = done_nx ? sum : result_q;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_OFF;
      res_q    <= '0;
      range_q  <= '0;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      mode_q   <= mode_nx;
      res_q    <= res_nx;
      range_q  <= range_nx;
      run_q    <= run_nx;
      done_q   <= done_nx;
      result_q <= result_nx;
    end
  end

  assign result   = result_q;
  assign done     = done_q;
  assign busy     = run_q;
  assign chan_ir  = dec_cur.ir;
  assign gain_sel = range_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R10
  AST_DONE_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(run_q)); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_q |-> $stable(result_q)); // R7
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_cur.active |-> !run_q); // R3
  AST_CFG_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_evt |=> !done_q); // R9
  AST_RESULT_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ((result_q & ~cap) == '0)); // R5
  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !dec_cur.cont) |-> !run_q); // R7
  AST_CONT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && dec_cur.cont) |-> run_q); // R8
endmodule

// File: tb/light_conv_seq_bench.sv
module light_conv_seq_bench;
  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_wr;
  logic        ctrl_wr;
  logic [7:0]  wr_data;
  logic        mod_pulse;
  logic [15:0] result;
  logic        done;
  logic        busy;
  logic        chan_ir;
  logic [1:0]  gain_sel;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int exp_val_q[$];
  int exp_cyc_q[$];
  string tag_q[$];
  int last_exp = 0;

  light_conv_seq u_light_conv_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .ctrl_wr(ctrl_wr),
    .wr_data(wr_data), .mod_pulse(mod_pulse), .result(result), .done(done),
    .busy(busy), .chan_ir(chan_ir), .gain_sel(gain_sel)
  );

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit pat(input int kind, input int i);
    case (kind)
      0: return 1'b0;
      1: return 1'b1;
      2: return (i % 2) == 0;
      3: return (i % 3) == 0;
      default: return (i % 5) == 0;
    endcase
  endfunction

  // monitor: compare every result load against the scoreboard
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_val_q.size() == 0) begin
        chk(1'b0, "R10", int'(result), -1, "unexpected done pulse");
      end else begin
        automatic int ev = exp_val_q.pop_front();
        automatic int ec = exp_cyc_q.pop_front();
        automatic string tg = tag_q.pop_front();
        chk(int'(result) == ev, tg, int'(result), ev, "window result");
        chk(cyc == ec, "R4", cyc, ec, "done cycle");
      end
    end
  end

  task automatic cfg_write(input bit m, input bit c, input logic [7:0] d);
    @(negedge clk);
    mode_wr = m; ctrl_wr = c; wr_data = d; mod_pulse = 1'b0;
    @(posedge clk);
    #1;
    mode_wr = 1'b0; ctrl_wr = 1'b0;
  endtask

  // driver: one window of len cycles; pushes the expected count
  task automatic drive_window(input int len, input int kind, input bit exp_ir, input string tag);
    int cnt = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk(busy == 1'b1, "R2", int'(busy), 1, "busy during window");
        chk(chan_ir == exp_ir, "R2", int'(chan_ir), int'(exp_ir), "channel select");
      end
      mod_pulse = pat(kind, i);
      cnt += int'(pat(kind, i));
    end
    if (cnt > len - 1) cnt = len - 1;
    exp_val_q.push_back(cnt);
    exp_cyc_q.push_back(cyc + 1);
    tag_q.push_back(tag);
    last_exp = cnt;
  endtask

  task automatic idle_watch(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mod_pulse = 1'b1;
    end
    @(negedge clk);
    mod_pulse = 1'b0;
    chk(busy == 1'b0, tag, int'(busy), 0, "stays powered down");
    chk(int'(result) == last_exp, tag, int'(result), last_exp, "result held");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hang expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode_wr = 1'b0; ctrl_wr = 1'b0; wr_data = '0; mod_pulse = 1'b0;
    repeat (3) @(negedge clk);
    chk(result == 16'd0, "R1", int'(result), 0, "reset result");
    chk(busy == 1'b0, "R1", int'(busy), 0, "reset busy");
    chk(done == 1'b0, "R1", int'(done), 0, "reset done");
    chk(gain_sel == 2'd0, "R1", int'(gain_sel), 0, "reset gain");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // continuous ALS, 4-bit windows, range 1
    cfg_write(1'b0, 1'b1, 8'h0D);
    cfg_write(1'b1, 1'b0, 8'hA0);
    chk(gain_sel == 2'd1, "R11", int'(gain_sel), 1, "range pass-through");
    drive_window(16, 1, 1'b0, "R6");
    drive_window(16, 2, 1'b0, "R8");
    drive_window(16, 0, 1'b0, "R8");
    drive_window(16, 3, 1'b0, "R5");
    cfg_write(1'b1, 1'b0, 8'h00); // R12: stop continuous run
    chk(busy == 1'b0, "R12", int'(busy), 0, "busy after power-down write");
    idle_watch(30, "R12");

    // ALS one-shot, 8-bit window, range 2
    cfg_write(1'b0, 1'b1, 8'h0A);
    chk(gain_sel == 2'd2, "R11", int'(gain_sel), 2, "range pass-through");
    cfg_write(1'b1, 1'b0, 8'h20);
    drive_window(256, 3, 1'b0, "R5");
    idle_watch(40, "R7");

    // IR one-shot, 12-bit window, range 3
    cfg_write(1'b0, 1'b1, 8'h07);
    cfg_write(1'b1, 1'b0, 8'h40);
    drive_window(4096, 4, 1'b1, "R4");
    idle_watch(20, "R7");

    // reserved codes behave like power-down
    cfg_write(1'b1, 1'b0, 8'h60); // 011
    idle_watch(40, "R3");
    cfg_write(1'b1, 1'b0, 8'h80); // 100
    idle_watch(40, "R3");
    cfg_write(1'b1, 1'b0, 8'hE0); // 111
    idle_watch(40, "R3");

    // abort: IR continuous at 4 bits, then change resolution mid-window
    cfg_write(1'b0, 1'b1, 8'h0C);
    cfg_write(1'b1, 1'b0, 8'hC0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      mod_pulse = 1'b1;
    end
    cfg_write(1'b0, 1'b1, 8'h0A);
    chk(int'(result) == last_exp, "R9", int'(result), last_exp, "result kept on abort");
    chk(busy == 1'b1, "R9", int'(busy), 1, "new window started");
    drive_window(256, 2, 1'b1, "R9");
    drive_window(256, 1, 1'b1, "R6");
    cfg_write(1'b1, 1'b0, 8'h00);
    idle_watch(10, "R12");

    // full 16-bit window with constant strobes
    cfg_write(1'b0, 1'b1, 8'h00);
    cfg_write(1'b1, 1'b0, 8'h20);
    drive_window(65536, 1, 1'b0, "R6");
    idle_watch(5, "R7");
    chk(result == 16'hFFFF, "R6", int'(result), 65535, "16-bit full scale");

    repeat (4) @(negedge clk);
    chk(exp_val_q.size() == 0, "R10", exp_val_q.size(), 0, "windows without done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule